// File: doc/BRIEF.md
# Denormal Operand Guard for a Four-Lane Float Vector Path

This block runs next to a vector datapath that processes four single-precision lanes per operation. For every issued operation it inspects both source operands and the result. Each lane is classified as zero, normal or subnormal. When the control word asks for it, subnormal inputs are replaced by signed zeros, and subnormal results from floating-point arithmetic are replaced by signed zeros. The arithmetic is not done here: the result vector comes from an external unit in the same cycle.

The block also tells a stall controller when an operation must pay an extra preparation step. A small tag table keeps one 2-bit tag per architectural register. The tag records which kind of operation last wrote that register. An input penalty depends on the operand being subnormal, on the producer of the register, and on the kind of operation consuming it. Once an input has been prepared, its register tag is marked so that the same value is not charged again. An output penalty is requested when a floating-point result is subnormal and both the inexact and underflow exceptions are masked. All outputs are combinational on the issue strobe. The tag table updates at the next clock edge.

Top module: `dnm_guard`

## Requirements
- R1: A 32-bit lane is subnormal exactly when bits 30:23 are all zero and bits 22:0 are not all zero. Zero lanes (either sign) and lanes with a non-zero exponent are never altered and never cause a penalty.
- R2: Operation kind encoding: 00 = float compute, 01 = load, 10 = integer/logic, 11 = no-op. When ctrl_word bit 6 is set and the kind is float compute, every subnormal lane of both operand outputs becomes {sign, 31 zeros}, and `pre_pen` stays low. For other kinds, operands pass unchanged.
- R3: When ctrl_word bit 15 is set and the kind is float compute, every subnormal lane of `res_out` becomes {sign, 31 zeros}, and `post_pen` stays low. For every other kind, the result passes unchanged.
- R4: `post_pen` is high only for a valid float-compute operation whose result has a subnormal lane, with ctrl_word bits 11 and 12 both set and bit 15 clear.
- R5: A valid float-compute operation raises `pre_pen` when a register source (A always, B when `src_b_mem` is 0) has a subnormal lane, bit 6 is clear, and that register's tag is 01 (load) or 10 (integer/logic). Tags 00 (float) and 11 (prepared) raise nothing.
- R6: A B operand flagged as coming from memory (`src_b_mem` = 1) never causes `pre_pen` and never changes a tag.
- R7: A valid integer/logic operation raises `pre_pen` when a register source has a subnormal lane and its tag is 00 (float). Bit 6 has no effect on this, and integer/logic operations never alter their operands.
- R8: At reset every tag is 11. Each valid operation of kind 00, 01 or 10 writes the destination tag as 00, 01 or 10 respectively. A source that raised a penalty has its tag set to 11, unless it is also the destination; in that case the destination write wins.
- R9: `pre_pen` and `post_pen` are low whenever `iss_valid` is low. A no-op (kind 11) raises no penalty and writes no tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Operation issued this cycle |
| iss_kind | input | 2 | Operation kind (00 float, 01 load, 10 int/logic, 11 no-op) |
| src_a_idx | input | 3 | Register index of operand A |
| src_a_data | input | 128 | Operand A, four 32-bit lanes |
| src_b_idx | input | 3 | Register index of operand B |
| src_b_data | input | 128 | Operand B, four 32-bit lanes |
| src_b_mem | input | 1 | Operand B comes from memory, not a register |
| dst_idx | input | 3 | Destination register index |
| ctrl_word | input | 16 | Floating-point control word (bits 6, 11, 12, 15 used) |
| res_in | input | 128 | Result from the external arithmetic unit or load path |
| opnd_a_out | output | 128 | Operand A after input zeroing |
| opnd_b_out | output | 128 | Operand B after input zeroing |
| res_out | output | 128 | Result after output flushing |
| pre_pen | output | 1 | Input-preparation penalty request |
| post_pen | output | 1 | Output-fixup penalty request |

## Verification
The assertions assume that `iss_kind`, the indices and `ctrl_word` are held steady through each cycle and only change after the active clock edge. They also assume that a destination tag read in the cycle after an issue reflects that single issue, which holds only when operations arrive at most once per clock. The stimulus changes all inputs just after the rising edge and keeps one operation per cycle. It mixes register and memory B operands, repeats reads of the same register to exercise the once-only charge, and makes a source the destination to exercise write priority.

// File: rtl/dnm_pkg.sv
package dnm_pkg;
  localparam int LANE_W = 32;

  typedef enum logic [1:0] {
    K_FP   = 2'b00,
    K_LOAD = 2'b01,
    K_INT  = 2'b10,
    K_NOP  = 2'b11
  } op_kind_e;

  typedef enum logic [1:0] {
    T_FLT = 2'b00,
    T_LD  = 2'b01,
    T_INT = 2'b10,
    T_RDY = 2'b11
  } src_tag_e;

  localparam int CW_DAZ = 6;
  localparam int CW_PM  = 11;
  localparam int CW_UM  = 12;
  localparam int CW_FTZ = 15;

  // subnormal: zero exponent, non-zero fraction
  function automatic logic lane_subn(input logic [LANE_W-1:0] x);
    return (x[30:23] == 8'h00) && (x[22:0] != 23'h0);
  endfunction

  // keep sign, clear magnitude
  function automatic logic [LANE_W-1:0] lane_signed_zero(input logic [LANE_W-1:0] x);
    return {x[31], {(LANE_W-1){1'b0}}};
  endfunction

  // tag written for the destination by each operation kind
  function automatic logic [1:0] kind_to_tag(input logic [1:0] k);
    case (k)
      K_FP:    return T_FLT;
      K_LOAD:  return T_LD;
      default: return T_INT;
    endcase
  endfunction

  // does a subnormal register source need preparation for this consumer
  function automatic logic needs_prep(input logic [1:0] k, input logic [1:0] tag,
                                      input logic subn, input logic daz);
    case (k)
      K_FP:    return subn && !daz && (tag == T_LD || tag == T_INT);
      K_INT:   return subn && (tag == T_FLT);
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dnm_lane_scan.sv
module dnm_lane_scan #(
  parameter int LANES = 4
) (
  input  logic [LANES*dnm_pkg::LANE_W-1:0] vec_in,
  input  logic                             zap,
  output logic [LANES*dnm_pkg::LANE_W-1:0] vec_out,
  output logic [LANES-1:0]                 subn_mask,
  output logic                             subn_any
);
  import dnm_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane;
    assign lane = vec_in[g*LANE_W +: LANE_W];
    assign subn_mask[g] = lane_subn(lane);
    assign vec_out[g*LANE_W +: LANE_W] = (zap && subn_mask[g]) ? lane_signed_zero(lane) : lane;
  end

  assign subn_any = |subn_mask;
endmodule

// File: rtl/dnm_tag_file.sv
module dnm_tag_file #(
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [1:0]      wr_tag,
  input  logic            rdy_a_en,
  input  logic [IW-1:0]   rdy_a_idx,
  input  logic            rdy_b_en,
  input  logic [IW-1:0]   rdy_b_idx,
  input  logic [IW-1:0]   rd_a_idx,
  input  logic [IW-1:0]   rd_b_idx,
  output logic [1:0]      rd_a_tag,
  output logic [1:0]      rd_b_tag,
  output logic [2*NREG-1:0] tag_vec
);
  import dnm_pkg::*;

  logic [NREG-1:0][1:0] tag_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit_wr, hit_rdy;
    assign hit_wr  = wr_en && (wr_idx == IW'(r));
    assign hit_rdy = (rdy_a_en && (rdy_a_idx == IW'(r))) ||
                     (rdy_b_en && (rdy_b_idx == IW'(r)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tag_q[r] <= T_RDY;
      else if (hit_wr)  tag_q[r] <= wr_tag;   // destination write wins
      else if (hit_rdy) tag_q[r] <= T_RDY;
    end
    assign tag_vec[2*r +: 2] = tag_q[r];
  end

  assign rd_a_tag = tag_q[rd_a_idx];
  assign rd_b_tag = tag_q[rd_b_idx];
endmodule

// File: rtl/dnm_guard.sv
module dnm_guard #(
  parameter int LANES = 4,
  parameter int NREG  = 8,
  localparam int VW   = LANES * dnm_pkg::LANE_W,
  localparam int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [1:0]    iss_kind,
  input  logic [IW-1:0] src_a_idx,
  input  logic [VW-1:0] src_a_data,
  input  logic [IW-1:0] src_b_idx,
  input  logic [VW-1:0] src_b_data,
  input  logic          src_b_mem,
  input  logic [IW-1:0] dst_idx,
  input  logic [15:0]   ctrl_word,
  input  logic [VW-1:0] res_in,
  output logic [VW-1:0] opnd_a_out,
  output logic [VW-1:0] opnd_b_out,
  output logic [VW-1:0] res_out,
  output logic          pre_pen,
  output logic          post_pen
);
  import dnm_pkg::*;

  // control fields
  logic daz_on, ftz_on, masks_on, kind_fp, ctrl_unused;
  assign daz_on   = ctrl_word[CW_DAZ];
  assign ftz_on   = ctrl_word[CW_FTZ];
  assign masks_on = ctrl_word[CW_PM] && ctrl_word[CW_UM];
  assign kind_fp  = (iss_kind == K_FP);
  assign ctrl_unused = ^{ctrl_word[14:13], ctrl_word[10:7], ctrl_word[5:0]};

  // lane classification and zeroing
  logic [LANES-1:0] a_mask, b_mask, r_mask;
  logic a_subn_any, b_subn_any, r_subn_any;

  dnm_lane_scan #(.LANES(LANES)) u_scan_a (
    .vec_in(src_a_data), .zap(kind_fp && daz_on),
    .vec_out(opnd_a_out), .subn_mask(a_mask), .subn_any(a_subn_any));

  dnm_lane_scan #(.LANES(LANES)) u_scan_b (
    .vec_in(src_b_data), .zap(kind_fp && daz_on),
    .vec_out(opnd_b_out), .subn_mask(b_mask), .subn_any(b_subn_any));

  dnm_lane_scan #(.LANES(LANES)) u_scan_r (
    .vec_in(res_in), .zap(kind_fp && ftz_on),
    .vec_out(res_out), .subn_mask(r_mask), .subn_any(r_subn_any));

  // producer tags
  logic [1:0] tag_a, tag_b;
  logic [2*NREG-1:0] tag_vec;
  logic pen_a, pen_b, tag_wr;

  assign pen_a  = iss_valid && needs_prep(iss_kind, tag_a, a_subn_any, daz_on);
  assign pen_b  = iss_valid && !src_b_mem && needs_prep(iss_kind, tag_b, b_subn_any, daz_on);
  assign tag_wr = iss_valid && (iss_kind != K_NOP);

  dnm_tag_file #(.NREG(NREG)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tag_wr), .wr_idx(dst_idx), .wr_tag(kind_to_tag(iss_kind)),
    .rdy_a_en(pen_a), .rdy_a_idx(src_a_idx),
    .rdy_b_en(pen_b), .rdy_b_idx(src_b_idx),
    .rd_a_idx(src_a_idx), .rd_b_idx(src_b_idx),
    .rd_a_tag(tag_a), .rd_b_tag(tag_b), .tag_vec(tag_vec));

  // penalty requests
  assign pre_pen  = pen_a || pen_b;
  assign post_pen = iss_valid && kind_fp && r_subn_any && masks_on && !ftz_on;
endmodule

// File: rtl/dnm_guard_chk.sv
module dnm_guard_chk #(
  parameter int LANES = 4,
  parameter int NREG  = 8,
  localparam int VW   = LANES * dnm_pkg::LANE_W,
  localparam int IW   = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic [1:0]      iss_kind,
  input logic [IW-1:0]   src_a_idx,
  input logic [IW-1:0]   dst_idx,
  input logic            src_b_mem,
  input logic [15:0]     ctrl_word,
  input logic [VW-1:0]   res_out,
  input logic            pre_pen,
  input logic            post_pen,
  input logic            pen_a,
  input logic            pen_b,
  input logic            a_subn_any,
  input logic            b_subn_any,
  input logic [2*NREG-1:0] tag_vec
);
  import dnm_pkg::*;

  function automatic logic vec_has_subn(input logic [VW-1:0] v);
    logic hit = 1'b0;
    for (int i = 0; i < LANES; i++) hit |= lane_subn(v[i*LANE_W +: LANE_W]);
    return hit;
  endfunction

  // remember last issue to check the tag table one cycle later
  logic          rdy_chk_q, wr_chk_q;
  logic [IW-1:0] rdy_idx_q, wr_idx_q;
  logic [1:0]    wr_tag_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_chk_q <= 1'b0; wr_chk_q <= 1'b0;
      rdy_idx_q <= '0;   wr_idx_q <= '0; wr_tag_q <= 2'b00;
    end else begin
      rdy_chk_q <= pen_a && (src_a_idx != dst_idx);
      rdy_idx_q <= src_a_idx;
      wr_chk_q  <= iss_valid && (iss_kind != K_NOP);
      wr_idx_q  <= dst_idx;
      wr_tag_q  <= iss_kind;
    end
  end

  p_no_pulse_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_pen || post_pen) |-> iss_valid);

  p_pre_has_subn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_pen |-> (a_subn_any || b_subn_any));

  p_mem_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    src_b_mem |-> !pen_b);

  p_daz_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_kind == K_FP && ctrl_word[CW_DAZ]) |-> !pre_pen);

  p_post_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    post_pen |-> (iss_kind == K_FP && ctrl_word[CW_PM] && ctrl_word[CW_UM] && !ctrl_word[CW_FTZ]));

  p_ftz_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_kind == K_FP && ctrl_word[CW_FTZ]) |-> !vec_has_subn(res_out));

  p_nop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_kind == K_NOP) |-> !(pre_pen || post_pen));

  p_src_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_chk_q |-> (tag_vec[2*rdy_idx_q +: 2] == T_RDY));

  p_dst_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chk_q |-> (tag_vec[2*wr_idx_q +: 2] == wr_tag_q));
endmodule

bind dnm_guard dnm_guard_chk #(.LANES(LANES), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_kind(iss_kind),
  .src_a_idx(src_a_idx), .dst_idx(dst_idx), .src_b_mem(src_b_mem),
  .ctrl_word(ctrl_word), .res_out(res_out), .pre_pen(pre_pen), .post_pen(post_pen),
  .pen_a(pen_a), .pen_b(pen_b), .a_subn_any(a_subn_any), .b_subn_any(b_subn_any),
  .tag_vec(tag_vec));

// File: tb/dnm_guard_bench.sv
module dnm_guard_bench;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic         iss_valid = 1'b0, src_b_mem = 1'b0;
  logic [1:0]   iss_kind = 2'b11;
  logic [2:0]   src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
  logic [127:0] src_a_data = '0, src_b_data = '0, res_in = '0;
  logic [15:0]  ctrl_word = '0;
  logic [127:0] opnd_a_out, opnd_b_out, res_out;
  logic         pre_pen, post_pen;

  dnm_guard u_dnm_guard (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_kind(iss_kind),
    .src_a_idx(src_a_idx), .src_a_data(src_a_data), .src_b_idx(src_b_idx),
    .src_b_data(src_b_data), .src_b_mem(src_b_mem), .dst_idx(dst_idx),
    .ctrl_word(ctrl_word), .res_in(res_in), .opnd_a_out(opnd_a_out),
    .opnd_b_out(opnd_b_out), .res_out(res_out), .pre_pen(pre_pen), .post_pen(post_pen));

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [1:0] mtag [NREG];
  logic [385:0] exp_q [$];
  string        req_q [$];

  // reference restatement of the lane rules
  function automatic bit is_sub(input logic [31:0] x);
    return (x[30:23] == 0) && (x[22:0] != 0);
  endfunction
  function automatic bit any_sub(input logic [127:0] v);
    bit h = 0;
    for (int i = 0; i < 4; i++) if (is_sub(v[32*i +: 32])) h = 1;
    return h;
  endfunction
  function automatic logic [127:0] zero_sub(input logic [127:0] v);
    logic [127:0] o = v;
    for (int i = 0; i < 4; i++) if (is_sub(v[32*i +: 32])) o[32*i +: 32] = {v[32*i+31], 31'b0};
    return o;
  endfunction
  function automatic bit src_pen(input logic [1:0] k, input logic [1:0] t,
                                 input logic [127:0] d, input bit daz);
    if (k == 2'b00) return any_sub(d) && !daz && (t == 2'b01 || t == 2'b10);
    if (k == 2'b10) return any_sub(d) && (t == 2'b00);
    return 0;
  endfunction

  task automatic issue(input logic [1:0] k, input int ai, input logic [127:0] ad,
                       input int bi, input logic [127:0] bd, input bit bm, input int di,
                       input logic [15:0] cw, input logic [127:0] rd, input string req);
    bit fp, daz, ftz, pa, pb, post;
    logic [127:0] ea, eb, er;
    @(posedge clk); #1;
    fp = (k == 2'b00); daz = cw[6]; ftz = cw[15];
    ea = (fp && daz) ? zero_sub(ad) : ad;
    eb = (fp && daz) ? zero_sub(bd) : bd;
    er = (fp && ftz) ? zero_sub(rd) : rd;
    pa = src_pen(k, mtag[ai], ad, daz);
    pb = !bm && src_pen(k, mtag[bi], bd, daz);
    post = fp && any_sub(rd) && cw[11] && cw[12] && !ftz;
    if (pa) mtag[ai] = 2'b11;
    if (pb) mtag[bi] = 2'b11;
    if (k != 2'b11) mtag[di] = (k == 2'b00) ? 2'b00 : (k == 2'b01) ? 2'b01 : 2'b10;
    iss_valid = 1; iss_kind = k; src_a_idx = 3'(ai); src_a_data = ad;
    src_b_idx = 3'(bi); src_b_data = bd; src_b_mem = bm; dst_idx = 3'(di);
    ctrl_word = cw; res_in = rd;
    exp_q.push_back({pa || pb, post, ea, eb, er});
    req_q.push_back(req);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && iss_valid && !finished) begin
      logic [385:0] got, want;
      string r;
      got = {pre_pen, post_pen, opnd_a_out, opnd_b_out, res_out};
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s: actual=%h expected=<none>", "R9", got);
      end else begin
        want = exp_q.pop_front();
        r = req_q.pop_front();
        if (got !== want) begin
          bad++;
          $display("FAIL %s: actual pre=%b post=%b a=%h b=%h r=%h expected pre=%b post=%b a=%h b=%h r=%h",
                   r, got[385], got[384], got[383:256], got[255:128], got[127:0],
                   want[385], want[384], want[383:256], want[255:128], want[127:0]);
        end
      end
    end
  end

  localparam logic [31:0] D  = 32'h0000_1234, ND = 32'h8000_0040, N = 32'h3f80_0000;
  localparam logic [31:0] MX = 32'h007f_ffff, MN = 32'h0080_0000, Z = 32'h0, NZ = 32'h8000_0000;
  localparam logic [127:0] VN = {N, N, N, N}, VD2 = {N, D, N, N}, VND = {ND, N, MN, Z};
  localparam logic [127:0] VMX = {Z, N, N, MX}, VEDGE = {MN, NZ, Z, N};
  localparam logic [15:0] CM = 16'h1800, CDAZ = 16'h0040, CFTZ = 16'h8000;
  localparam logic [1:0] FP = 2'b00, LD = 2'b01, IN = 2'b10, NOP = 2'b11;

  initial begin
    for (int i = 0; i < NREG; i++) mtag[i] = 2'b11;
    // reset state, idle strobe with subnormal data: R9
    src_a_data = VD2; res_in = VND; ctrl_word = CM; iss_kind = FP;
    repeat (3) @(negedge clk);
    total++;
    if (pre_pen !== 1'b0 || post_pen !== 1'b0) begin
      bad++; $display("FAIL R9: actual pre=%b post=%b expected 0 0", pre_pen, post_pen);
    end
    rst_n = 1'b1;
    issue(FP, 1, VD2, 2, VN, 0, 2, 0, VN, "R8");     // reset tags ready
    issue(LD, 0, VN, 0, VN, 0, 3, 0, VD2, "R8");
    issue(FP, 3, VD2, 2, VN, 0, 4, 0, VN, "R5");     // load-produced: charge
    issue(FP, 3, VD2, 2, VN, 0, 5, 0, VN, "R5");     // once only
    issue(LD, 0, VN, 0, VN, 0, 3, 0, VND, "R8");
    issue(FP, 3, VND, 2, VEDGE, 0, 4, CDAZ, VN, "R2");
    issue(LD, 0, VN, 0, VN, 0, 5, 0, VMX, "R8");
    issue(FP, 2, VN, 5, VMX, 1, 6, 0, VN, "R6");     // memory operand
    issue(FP, 2, VN, 5, VMX, 0, 6, 0, VN, "R5");     // same via register
    issue(IN, 4, VD2, 2, VN, 0, 6, CDAZ, VD2, "R7"); // float-produced into int
    issue(FP, 6, VMX, 2, VN, 0, 1, 0, VN, "R5");     // int-produced into float
    issue(LD, 0, VN, 0, VN, 0, 7, 0, VD2, "R8");
    issue(IN, 7, VD2, 2, VN, 0, 0, 0, VN, "R7");     // load-produced into int
    issue(LD, 0, VN, 0, VN, 0, 3, 0, VD2, "R8");
    issue(FP, 3, VD2, 2, VN, 0, 3, 0, VN, "R8");     // dst is the source
    issue(IN, 3, VD2, 2, VN, 0, 0, 0, VN, "R8");
    issue(FP, 2, VN, 2, VN, 0, 1, CM, VND, "R4");
    issue(FP, 2, VN, 2, VN, 0, 1, 16'h0800, VND, "R4");
    issue(FP, 2, VN, 2, VN, 0, 1, CM | CFTZ, VND, "R3");
    issue(LD, 2, VN, 2, VN, 0, 1, CM | CFTZ, VND, "R3");
    issue(FP, 2, VN, 2, VN, 0, 1, CM, VEDGE, "R1");
    issue(FP, 2, VN, 2, VN, 0, 1, CM, VMX, "R1");
    issue(LD, 0, VN, 0, VN, 0, 5, 0, VEDGE, "R1");
    issue(FP, 5, VEDGE, 2, VN, 0, 1, CDAZ, VN, "R1");
    issue(FP, 5, VEDGE, 2, VN, 0, 1, 0, VN, "R1");
    issue(LD, 0, VN, 0, VN, 0, 7, 0, VD2, "R8");
    issue(NOP, 7, VD2, 7, VD2, 0, 7, CM, VND, "R9");
    issue(FP, 7, VD2, 2, VN, 0, 0, 0, VN, "R9");     // no-op left tag alone
    @(posedge clk); #1 iss_valid = 1'b0;
    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R9: actual pending=%0d expected 0", exp_q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL R9: actual watchdog expired expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule